// File: doc/BRIEF.md
# Mode-Banked CPU Register File

This block is the general-purpose register file of a 32-bit processor core. Software sees sixteen registers by index. Behind some of those indices sit several physical copies, and the processor mode picks which copy answers. The register file keeps its own current-mode register. That register loads the 5-bit mode input on every rising clock edge. The decoded mode then steers two combinational read ports, one write port and a saved-status port. The register file also has a user-view port for the handful of instructions that must reach the user-mode copies while running in a privileged mode. A one-cycle preset strobe loads the boot values that a boot sequence expects.

The mode register acts as the block's state machine. Its states are seven modes: USER (0b10000), FAST_IRQ (0b10001), IRQ (0b10010), SUPERVISOR (0b10011), ABORT (0b10111), UNDEFINED (0b11011) and SYSTEM (0b11111). It also has an INVALID state, which covers every other code and behaves as USER. Reset enters SYSTEM. On each clock edge the block makes the transition LOAD, which moves from any state to the state that `mode_i` encodes. No other transition exists. Writes that are presented in a cycle use the mode that was current before that cycle's edge.

Top module: `bank_regfile`

## Requirements
- R1: After reset, `cur_mode_o` is 0x1F (SYSTEM) and every physical copy of every register, and every saved-status copy, reads zero.
- R2: `cur_mode_o` takes the value of `mode_i` at every rising edge. A value that is not one of the seven mode codes sets `mode_err_o` while it is current, and the register file then banks exactly as in USER.
- R3: Indices 0 to 7 and 15 each have one physical copy, and all modes share it.
- R4: Indices 8 to 12 have two copies. FAST_IRQ (0b10001) uses a private copy. All other modes use the shared copy.
- R5: Indices 13 and 14 have six copies, one per group: USER/SYSTEM together, SUPERVISOR, ABORT, UNDEFINED, IRQ and FAST_IRQ.
- R6: The user-view read and write ports reach, in any mode, the copy that USER would reach for the same index. This means the shared copies of 8 to 12, the USER/SYSTEM copies of 13 and 14, and the single copies of the rest.
- R7: SUPERVISOR, ABORT, UNDEFINED, IRQ and FAST_IRQ each own one saved-status word. `sav_rd_data_o` shows the copy for the current mode, and `sav_wr_en_i` writes that copy.
- R8: In USER, in SYSTEM or in an invalid mode, a saved-status access behaves as follows. `sav_rd_data_o` reads zero. A write changes no saved-status copy. `sav_err_o` is high in the same cycle as the access (`sav_rd_en_i` or `sav_wr_en_i`) and low in every other cycle.
- R9: Reads are combinational. A read of a register that is being written in the same cycle returns the old value. The new value is visible after the edge. A write that is presented together with a mode change lands in the copy that belongs to the mode before the edge.
- R10: If the normal and user-view write ports target the same physical copy in one cycle, the normal port's data is stored.
- R11: A cycle with `preset_i` high stores the following values: 0x03007F00 into the USER/SYSTEM index-13 copy, 0x08000000 into index 15, 0x03007FA0 into the IRQ index-13 copy and 0x03007FE0 into the SUPERVISOR index-13 copy. All three write ports are ignored in that cycle, and every other copy keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Mode code loaded at each edge |
| preset_i | input | 1 | Boot-value load strobe |
| rd_a_idx_i | input | 4 | Read port A index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Normal write enable |
| wr_idx_i | input | 4 | Normal write index |
| wr_data_i | input | 32 | Normal write data |
| usr_rd_idx_i | input | 4 | User-view read index |
| usr_rd_data_o | output | 32 | User-view read data |
| usr_wr_en_i | input | 1 | User-view write enable |
| usr_wr_idx_i | input | 4 | User-view write index |
| usr_wr_data_i | input | 32 | User-view write data |
| sav_rd_en_i | input | 1 | Saved-status read strobe |
| sav_rd_data_o | output | 32 | Saved-status word of current mode |
| sav_wr_en_i | input | 1 | Saved-status write enable |
| sav_wr_data_i | input | 32 | Saved-status write data |
| cur_mode_o | output | 5 | Current mode code |
| mode_err_o | output | 1 | Current mode code is invalid |
| sav_err_o | output | 1 | Saved-status access in a mode without one |

## Verification
The hardest case to reach from the ports is a write that is presented in the same cycle as a mode change. The value must land in the copy of the outgoing mode, and no port shows that copy until the mode returns. The stimulus for this case holds `mode_i` at FAST_IRQ while writing index 10 from USER. It then reads index 10 in FAST_IRQ, where the private copy is expected to be zero, and again after switching back to USER. The user-view port in a privileged mode is the only way to cross banks without a mode switch, so the bench pairs each user-view write with a later switch into USER or SYSTEM. It also checks the privileged copy of the same index to confirm that copy was left alone.

// File: rtl/bank_pkg.sv
package bank_pkg;

    localparam int MODE_W    = 5;
    localparam int IDX_W     = 4;
    localparam int N_LOW     = 9;    // indices 0..7 and 15
    localparam int N_HIGH    = 5;    // indices 8..12
    localparam int N_GRP     = 6;    // stack/link groups
    localparam int N_SAVED   = 5;    // saved-status owners
    localparam int HIGH_BASE = N_LOW;
    localparam int PAIR_BASE = N_LOW + 2 * N_HIGH;
    localparam int N_PHYS    = PAIR_BASE + 2 * N_GRP;
    localparam int PHYS_W    = $clog2(N_PHYS);
    localparam int SAV_W     = $clog2(N_SAVED);

    typedef enum logic [MODE_W-1:0] {
        MD_USR = 5'b10000,
        MD_FIQ = 5'b10001,
        MD_IRQ = 5'b10010,
        MD_SVC = 5'b10011,
        MD_ABT = 5'b10111,
        MD_UND = 5'b11011,
        MD_SYS = 5'b11111
    } mode_e;

    typedef enum logic [2:0] {
        GRP_USR = 3'd0,
        GRP_SVC = 3'd1,
        GRP_ABT = 3'd2,
        GRP_UND = 3'd3,
        GRP_IRQ = 3'd4,
        GRP_FIQ = 3'd5
    } grp_e;

    // Map an architectural index seen by a bank group to a physical slot.
    function automatic logic [PHYS_W-1:0] phys_slot(input logic [IDX_W-1:0] idx,
                                                    input grp_e grp);
        int s;
        if (idx <= 4'd7) begin
            s = int'(idx);
        end else if (idx == 4'd15) begin
            s = N_LOW - 1;
        end else if (idx <= 4'd12) begin
            s = HIGH_BASE + 2 * (int'(idx) - 8) + ((grp == GRP_FIQ) ? 1 : 0);
        end else begin
            s = PAIR_BASE + 2 * int'(grp) + (int'(idx) - 13);
        end
        return PHYS_W'(s);
    endfunction

    localparam logic [PHYS_W-1:0] SLOT_PC      = phys_slot(4'd15, GRP_USR);
    localparam logic [PHYS_W-1:0] SLOT_USR_SP  = phys_slot(4'd13, GRP_USR);
    localparam logic [PHYS_W-1:0] SLOT_IRQ_SP  = phys_slot(4'd13, GRP_IRQ);
    localparam logic [PHYS_W-1:0] SLOT_SVC_SP  = phys_slot(4'd13, GRP_SVC);

    localparam logic [31:0] BOOT_PC     = 32'h0800_0000;
    localparam logic [31:0] BOOT_USR_SP = 32'h0300_7F00;
    localparam logic [31:0] BOOT_IRQ_SP = 32'h0300_7FA0;
    localparam logic [31:0] BOOT_SVC_SP = 32'h0300_7FE0;

endpackage

// File: rtl/bank_mode_ctl.sv
module bank_mode_ctl
    import bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    output logic [MODE_W-1:0] mode_o,
    output grp_e              grp_o,
    output logic              valid_o,
    output logic              has_saved_o
);

    logic [MODE_W-1:0] mode_q;

    // State register: LOAD transition on every edge, reset enters SYSTEM.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_SYS;
        end else begin
            mode_q <= mode_i;
        end
    end

    // Output decode of the current state.
    always_comb begin
        grp_o       = GRP_USR;
        valid_o     = 1'b1;
        has_saved_o = 1'b0;
        unique case (mode_q)
            MD_USR: grp_o = GRP_USR;
            MD_SYS: grp_o = GRP_USR;
            MD_FIQ: begin grp_o = GRP_FIQ; has_saved_o = 1'b1; end
            MD_IRQ: begin grp_o = GRP_IRQ; has_saved_o = 1'b1; end
            MD_SVC: begin grp_o = GRP_SVC; has_saved_o = 1'b1; end
            MD_ABT: begin grp_o = GRP_ABT; has_saved_o = 1'b1; end
            MD_UND: begin grp_o = GRP_UND; has_saved_o = 1'b1; end
            default: valid_o = 1'b0;
        endcase
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/bank_gpr_store.sv
module bank_gpr_store
    import bank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_RD   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  grp_e              grp_i,
    input  logic              preset_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              uwr_en_i,
    input  logic [IDX_W-1:0]  uwr_idx_i,
    input  logic [DATA_W-1:0] uwr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i  [N_RD],
    input  logic              rd_user_i [N_RD],
    output logic [DATA_W-1:0] rd_data_o [N_RD]
);

    logic [DATA_W-1:0] regs [N_PHYS];
    logic [PHYS_W-1:0] wslot;
    logic [PHYS_W-1:0] uslot;

    assign wslot = phys_slot(wr_idx_i, grp_i);
    assign uslot = phys_slot(uwr_idx_i, GRP_USR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N_PHYS; k++) begin
                regs[k] <= '0;
            end
        end else if (preset_i) begin
            regs[SLOT_PC]     <= DATA_W'(BOOT_PC);
            regs[SLOT_USR_SP] <= DATA_W'(BOOT_USR_SP);
            regs[SLOT_IRQ_SP] <= DATA_W'(BOOT_IRQ_SP);
            regs[SLOT_SVC_SP] <= DATA_W'(BOOT_SVC_SP);
        end else begin
            if (uwr_en_i) begin
                regs[uslot] <= uwr_data_i;
            end
            // Normal port is assigned last so it wins a shared target.
            if (wr_en_i) begin
                regs[wslot] <= wr_data_i;
            end
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        grp_e rgrp;
        assign rgrp         = rd_user_i[p] ? GRP_USR : grp_i;
        assign rd_data_o[p] = regs[phys_slot(rd_idx_i[p], rgrp)];
    end

endmodule

// File: rtl/bank_saved_store.sv
module bank_saved_store
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  grp_e              grp_i,
    input  logic              has_saved_i,
    input  logic              preset_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              err_o
);

    logic [DATA_W-1:0] saved [N_SAVED];
    logic [SAV_W-1:0]  sel;

    assign sel = has_saved_i ? SAV_W'(int'(grp_i) - 1) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N_SAVED; k++) begin
                saved[k] <= '0;
            end
        end else if (wr_en_i && has_saved_i && !preset_i) begin
            saved[sel] <= wr_data_i;
        end
    end

    assign rd_data_o = has_saved_i ? saved[sel] : '0;
    assign err_o     = (rd_en_i || wr_en_i) && !has_saved_i;

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic              preset_i,
    input  logic [3:0]        rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [3:0]        rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [3:0]        usr_rd_idx_i,
    output logic [DATA_W-1:0] usr_rd_data_o,
    input  logic              usr_wr_en_i,
    input  logic [3:0]        usr_wr_idx_i,
    input  logic [DATA_W-1:0] usr_wr_data_i,
    input  logic              sav_rd_en_i,
    output logic [DATA_W-1:0] sav_rd_data_o,
    input  logic              sav_wr_en_i,
    input  logic [DATA_W-1:0] sav_wr_data_i,
    output logic [4:0]        cur_mode_o,
    output logic              mode_err_o,
    output logic              sav_err_o
);

    localparam int N_RD = 3;

    grp_e              grp;
    logic              valid;
    logic              has_saved;
    logic [IDX_W-1:0]  rd_idx  [N_RD];
    logic              rd_user [N_RD];
    logic [DATA_W-1:0] rd_data [N_RD];

    bank_mode_ctl u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .mode_o      (cur_mode_o),
        .grp_o       (grp),
        .valid_o     (valid),
        .has_saved_o (has_saved)
    );

    assign rd_idx[0]  = rd_a_idx_i;
    assign rd_idx[1]  = rd_b_idx_i;
    assign rd_idx[2]  = usr_rd_idx_i;
    assign rd_user[0] = 1'b0;
    assign rd_user[1] = 1'b0;
    assign rd_user[2] = 1'b1;

    bank_gpr_store #(.DATA_W(DATA_W), .N_RD(N_RD)) u_gpr (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_i      (grp),
        .preset_i   (preset_i),
        .wr_en_i    (wr_en_i),
        .wr_idx_i   (wr_idx_i),
        .wr_data_i  (wr_data_i),
        .uwr_en_i   (usr_wr_en_i),
        .uwr_idx_i  (usr_wr_idx_i),
        .uwr_data_i (usr_wr_data_i),
        .rd_idx_i   (rd_idx),
        .rd_user_i  (rd_user),
        .rd_data_o  (rd_data)
    );

    assign rd_a_data_o   = rd_data[0];
    assign rd_b_data_o   = rd_data[1];
    assign usr_rd_data_o = rd_data[2];

    bank_saved_store #(.DATA_W(DATA_W)) u_saved (
        .clk         (clk),
        .rst_n       (rst_n),
        .grp_i       (grp),
        .has_saved_i (has_saved),
        .preset_i    (preset_i),
        .rd_en_i     (sav_rd_en_i),
        .wr_en_i     (sav_wr_en_i),
        .wr_data_i   (sav_wr_data_i),
        .rd_data_o   (sav_rd_data_o),
        .err_o       (sav_err_o)
    );

    assign mode_err_o = !valid;

endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        mode_i,
    input logic              preset_i,
    input logic [3:0]        rd_a_idx_i,
    input logic [DATA_W-1:0] rd_a_data_o,
    input logic              wr_en_i,
    input logic [3:0]        wr_idx_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [3:0]        usr_rd_idx_i,
    input logic [DATA_W-1:0] usr_rd_data_o,
    input logic              sav_rd_en_i,
    input logic [DATA_W-1:0] sav_rd_data_o,
    input logic              sav_wr_en_i,
    input logic [DATA_W-1:0] sav_wr_data_i,
    input logic [4:0]        cur_mode_o,
    input logic              mode_err_o,
    input logic              sav_err_o
);

    AST_MODE_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cur_mode_o == $past(mode_i)); // R2

    AST_INVALID_HAS_NO_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_err_o && (sav_rd_en_i || sav_wr_en_i)) |-> sav_err_o); // R2

    AST_SAVED_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sav_err_o |-> sav_rd_data_o == '0); // R8

    AST_SAVED_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sav_wr_en_i && !sav_err_o && !preset_i && mode_i == cur_mode_o)
        |=> sav_rd_data_o == $past(sav_wr_data_i)); // R7

    AST_WRITE_VISIBLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !preset_i && mode_i == cur_mode_o)
        |=> (rd_a_idx_i != $past(wr_idx_i) || rd_a_data_o == $past(wr_data_i))); // R9

    AST_PRESET_LOADS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        preset_i |=> (rd_a_idx_i != 4'd15 || rd_a_data_o == DATA_W'(32'h0800_0000))); // R11

    AST_USER_VIEW_LOW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx_i == usr_rd_idx_i && rd_a_idx_i < 4'd8) |-> rd_a_data_o == usr_rd_data_o); // R6

endmodule

bind bank_regfile bank_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .preset_i      (preset_i),
    .rd_a_idx_i    (rd_a_idx_i),
    .rd_a_data_o   (rd_a_data_o),
    .wr_en_i       (wr_en_i),
    .wr_idx_i      (wr_idx_i),
    .wr_data_i     (wr_data_i),
    .usr_rd_idx_i  (usr_rd_idx_i),
    .usr_rd_data_o (usr_rd_data_o),
    .sav_rd_en_i   (sav_rd_en_i),
    .sav_rd_data_o (sav_rd_data_o),
    .sav_wr_en_i   (sav_wr_en_i),
    .sav_wr_data_i (sav_wr_data_i),
    .cur_mode_o    (cur_mode_o),
    .mode_err_o    (mode_err_o),
    .sav_err_o     (sav_err_o)
);

// File: tb/tb_bank_regfile.sv
`timescale 1ns/1ps
module tb_bank_regfile;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = M_SYS;
    logic        preset_i = 1'b0;
    logic [3:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
    logic [3:0]  usr_rd_idx_i = '0, usr_wr_idx_i = '0;
    logic        wr_en_i = 1'b0, usr_wr_en_i = 1'b0;
    logic        sav_rd_en_i = 1'b0, sav_wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0, usr_wr_data_i = '0, sav_wr_data_i = '0;
    logic [31:0] rd_a_data_o, rd_b_data_o, usr_rd_data_o, sav_rd_data_o;
    logic [4:0]  cur_mode_o;
    logic        mode_err_o, sav_err_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bank_regfile dut (.*);

    // Group order: USR, SVC, ABT, UND, IRQ, FIQ
    function automatic logic [4:0] grp_mode(input int k);
        case (k)
            0: return M_USR;
            1: return M_SVC;
            2: return M_ABT;
            3: return M_UND;
            4: return M_IRQ;
            default: return M_FIQ;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic set_mode(input logic [4:0] m);
        mode_i = m;
        tick();
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] d);
        wr_en_i = 1'b1; wr_idx_i = i; wr_data_i = d;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] i, input logic [31:0] exp);
        @(negedge clk);
        rd_a_idx_i = i; rd_b_idx_i = i;
        #1;
        chk({tag, " portA"}, rd_a_data_o, exp);
        chk({tag, " portB"}, rd_b_data_o, exp);
    endtask

    task automatic usr_chk(input string tag, input logic [3:0] i, input logic [31:0] exp);
        @(negedge clk);
        usr_rd_idx_i = i;
        #1;
        chk(tag, usr_rd_data_o, exp);
    endtask

    task automatic sav_chk(input string tag, input logic [31:0] exp, input logic exp_err);
        @(negedge clk);
        sav_rd_en_i = 1'b1;
        #1;
        chk({tag, " data"}, sav_rd_data_o, exp);
        chk({tag, " err"}, {31'd0, sav_err_o}, {31'd0, exp_err});
        tick();
        sav_rd_en_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mode after reset", {27'd0, cur_mode_o}, {27'd0, M_SYS});
        chk("R1 no mode error", {31'd0, mode_err_o}, 32'd0);
        for (int i = 0; i < 16; i++) rd_chk("R1 clear", 4'(i), 32'd0);
        set_mode(M_FIQ);
        for (int i = 8; i < 15; i++) rd_chk("R1 clear fiq bank", 4'(i), 32'd0);
        sav_chk("R1 saved clear", 32'd0, 1'b0);
        set_mode(M_SYS);
    endtask

    task automatic t_low_shared();
        set_mode(M_SVC);
        wr(4'd3, 32'h1111_0003);
        set_mode(M_FIQ);
        rd_chk("R3 r3 shared", 4'd3, 32'h1111_0003);
        wr(4'd15, 32'h0000_0F15);
        set_mode(M_USR);
        rd_chk("R3 r15 shared", 4'd15, 32'h0000_0F15);
    endtask

    task automatic t_fiq_high();
        set_mode(M_USR);
        wr(4'd8, 32'hB0B0_0008);
        set_mode(M_FIQ);
        rd_chk("R4 fiq private empty", 4'd8, 32'd0);
        wr(4'd8, 32'hF1F1_0008);
        set_mode(M_USR);
        rd_chk("R4 user shared kept", 4'd8, 32'hB0B0_0008);
        set_mode(M_SVC);
        rd_chk("R4 svc uses shared", 4'd8, 32'hB0B0_0008);
        set_mode(M_FIQ);
        rd_chk("R4 fiq private kept", 4'd8, 32'hF1F1_0008);
    endtask

    task automatic t_stack();
        for (int k = 0; k < 6; k++) begin
            set_mode(grp_mode(k));
            wr(4'd13, 32'h0D00_0000 + 32'(k));
            wr(4'd14, 32'h0E00_0000 + 32'(k));
        end
        for (int k = 0; k < 6; k++) begin
            set_mode(grp_mode(k));
            rd_chk("R5 sp copy", 4'd13, 32'h0D00_0000 + 32'(k));
            rd_chk("R5 lr copy", 4'd14, 32'h0E00_0000 + 32'(k));
        end
        set_mode(M_SYS);
        rd_chk("R5 system shares user sp", 4'd13, 32'h0D00_0000);
        wr(4'd14, 32'h5555_1414);
        set_mode(M_USR);
        rd_chk("R5 user sees system lr", 4'd14, 32'h5555_1414);
    endtask

    task automatic t_user_view();
        set_mode(M_FIQ);
        usr_chk("R6 user view r8 in fiq", 4'd8, 32'hB0B0_0008);
        usr_chk("R6 user view r13 in fiq", 4'd13, 32'h0D00_0000);
        usr_chk("R6 user view r3", 4'd3, 32'h1111_0003);
        usr_wr_en_i = 1'b1; usr_wr_idx_i = 4'd9; usr_wr_data_i = 32'hC0DE_0009;
        tick();
        usr_wr_en_i = 1'b0;
        rd_chk("R6 fiq r9 untouched", 4'd9, 32'd0);
        set_mode(M_USR);
        rd_chk("R6 user r9 written", 4'd9, 32'hC0DE_0009);
        set_mode(M_IRQ);
        usr_chk("R6 user view r14 in irq", 4'd14, 32'h5555_1414);
        usr_wr_en_i = 1'b1; usr_wr_idx_i = 4'd14; usr_wr_data_i = 32'hAAAA_0014;
        tick();
        usr_wr_en_i = 1'b0;
        rd_chk("R6 irq lr untouched", 4'd14, 32'h0E00_0004);
        set_mode(M_SYS);
        rd_chk("R6 system lr written", 4'd14, 32'hAAAA_0014);
    endtask

    task automatic t_saved();
        for (int k = 1; k < 6; k++) begin
            set_mode(grp_mode(k));
            sav_wr_en_i = 1'b1; sav_wr_data_i = 32'h5A00_0000 + 32'(k);
            tick();
            sav_wr_en_i = 1'b0;
        end
        for (int k = 1; k < 6; k++) begin
            set_mode(grp_mode(k));
            sav_chk("R7 saved copy", 32'h5A00_0000 + 32'(k), 1'b0);
        end
    endtask

    task automatic t_saved_err();
        set_mode(M_USR);
        @(negedge clk);
        sav_wr_en_i = 1'b1; sav_wr_data_i = 32'hDEAD_BEEF;
        #1;
        chk("R8 err on user write", {31'd0, sav_err_o}, 32'd1);
        chk("R8 user read zero", sav_rd_data_o, 32'd0);
        tick();
        sav_wr_en_i = 1'b0;
        #1;
        chk("R8 err drops after access", {31'd0, sav_err_o}, 32'd0);
        set_mode(M_SYS);
        sav_chk("R8 system read", 32'd0, 1'b1);
        for (int k = 1; k < 6; k++) begin
            set_mode(grp_mode(k));
            sav_chk("R8 saved unchanged", 32'h5A00_0000 + 32'(k), 1'b0);
        end
        set_mode(5'b00101);
        chk("R2 invalid code reported", {27'd0, cur_mode_o}, 32'h05);
        chk("R2 mode error set", {31'd0, mode_err_o}, 32'd1);
        rd_chk("R2 invalid banks as user", 4'd13, 32'h0D00_0000);
        sav_chk("R8 invalid mode saved", 32'd0, 1'b1);
        set_mode(M_SVC);
        chk("R2 mode error clears", {31'd0, mode_err_o}, 32'd0);
    endtask

    task automatic t_same_cycle();
        set_mode(M_USR);
        @(negedge clk);
        wr_en_i = 1'b1; wr_idx_i = 4'd5; wr_data_i = 32'h0000_0077;
        rd_a_idx_i = 4'd5;
        #1;
        chk("R9 read old value", rd_a_data_o, 32'd0);
        tick();
        wr_en_i = 1'b0;
        chk("R9 new value after edge", rd_a_data_o, 32'h0000_0077);
        @(negedge clk);
        mode_i = M_FIQ;
        wr_en_i = 1'b1; wr_idx_i = 4'd10; wr_data_i = 32'h0000_1010;
        tick();
        wr_en_i = 1'b0;
        rd_chk("R9 write used old mode", 4'd10, 32'd0);
        set_mode(M_USR);
        rd_chk("R9 landed in shared copy", 4'd10, 32'h0000_1010);
    endtask

    task automatic t_conflict();
        set_mode(M_USR);
        @(negedge clk);
        wr_en_i = 1'b1; wr_idx_i = 4'd6; wr_data_i = 32'h0606_AAAA;
        usr_wr_en_i = 1'b1; usr_wr_idx_i = 4'd6; usr_wr_data_i = 32'h0606_BBBB;
        tick();
        wr_en_i = 1'b0; usr_wr_en_i = 1'b0;
        rd_chk("R10 normal port wins", 4'd6, 32'h0606_AAAA);
    endtask

    task automatic t_preset();
        set_mode(M_USR);
        @(negedge clk);
        preset_i = 1'b1;
        wr_en_i = 1'b1; wr_idx_i = 4'd0; wr_data_i = 32'hBAD0_0000;
        usr_wr_en_i = 1'b1; usr_wr_idx_i = 4'd1; usr_wr_data_i = 32'hBAD0_0001;
        tick();
        preset_i = 1'b0; wr_en_i = 1'b0; usr_wr_en_i = 1'b0;
        rd_chk("R11 pc preset", 4'd15, 32'h0800_0000);
        rd_chk("R11 user sp preset", 4'd13, 32'h0300_7F00);
        rd_chk("R11 write port ignored", 4'd0, 32'd0);
        rd_chk("R11 user port ignored", 4'd1, 32'd0);
        rd_chk("R11 other reg kept", 4'd3, 32'h1111_0003);
        set_mode(M_IRQ);
        rd_chk("R11 irq sp preset", 4'd13, 32'h0300_7FA0);
        set_mode(M_SVC);
        rd_chk("R11 svc sp preset", 4'd13, 32'h0300_7FE0);
        rd_chk("R11 svc lr kept", 4'd14, 32'h0E00_0001);
        @(negedge clk);
        preset_i = 1'b1; sav_wr_en_i = 1'b1; sav_wr_data_i = 32'hBAD0_0002;
        tick();
        preset_i = 1'b0; sav_wr_en_i = 1'b0;
        sav_chk("R11 saved write ignored", 32'h5A00_0001, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_low_shared();
        t_fiq_high();
        t_stack();
        t_user_view();
        t_saved();
        t_saved_err();
        t_same_cycle();
        t_conflict();
        t_preset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule